// File: doc/BRIEF.md
# Segmented Dual-Port Buffer RAM

This block is a byte-wide 1536-byte memory with two access ports. It sits between a host processor and an internal protocol sequencer. The host reaches every byte through an 11-bit byte address. The sequencer names a buffer by an 8-bit segment number and a byte offset inside it. Segments are 8 bytes long. The block scales the segment number by the segment size and adds the offset, so every buffer starts on an 8-byte boundary.

An address at or above the end of the array never faults. It is pulled back into the array by subtracting 400h, and the access goes ahead at the folded location. For either port, such an overrun also raises a one-cycle violation pulse that can feed an interrupt controller. When the host runs in big-endian bus mode, bit 0 of host addresses 00h to 07h is inverted, which exchanges the bytes of the low word registers.

Both request ports use valid/ready. A request is taken on a rising clock edge where valid and ready are both high. The host port never stalls. The sequencer port stalls only when it would write the same byte that the host writes in the same cycle. While stalled, the sequencer must hold valid and all its request fields steady until ready returns. Read data comes with its own valid strobe and cannot be back-pressured.

Top module: `seg_dpram`

## Requirements
- R1: A host write to byte address A below 1536 (0x600) stores the byte, and a later host read of A returns it. Read data and `h_rvalid` appear one cycle after the read is accepted. `h_rvalid` stays low for writes.
- R2: A sequencer access with segment S and offset O goes to physical byte S*8+O. Bytes written by one port can be read by the other, and sequencer read data arrives with `s_rvalid` one cycle after acceptance.
- R3: With `h_big_end`=1, host addresses 0x000 to 0x007 have bit 0 inverted (a write to 0x002 lands in byte 0x003). Host addresses from 0x008 up are unchanged, and with `h_big_end`=0 no address is changed.
- R4: A host address of 0x600 or more is replaced by that address minus 0x400, and the access proceeds there.
- R5: A sequencer physical address S*8+O of 0x600 or more is replaced by that value minus 0x400, and the access proceeds there.
- R6: `ram_viol` is high for exactly one cycle, the cycle after an accepted overrun access by either port. It stays low after accepted in-range accesses and after idle cycles.
- R7: `h_ready` is always 1. `s_ready` goes low only when both ports request a write to the same physical byte in the same cycle. The host write then lands first, and the held sequencer write lands on a later cycle, so the sequencer's byte is the final content. Writes to different bytes in the same cycle both land.
- R8: A read and a write to the same byte accepted in the same cycle return the byte's previous content to the reader.
- R9: After reset, `h_rvalid`, `s_rvalid` and `ram_viol` are 0 and `h_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_big_end | input | 1 | Host byte order: 1 = big-endian, swaps bit 0 of the low eight addresses |
| h_valid | input | 1 | Host request present |
| h_ready | output | 1 | Host request can be taken (always 1) |
| h_we | input | 1 | Host request is a write |
| h_addr | input | 11 | Host byte address |
| h_wdata | input | 8 | Host write byte |
| h_rvalid | output | 1 | Host read byte valid |
| h_rdata | output | 8 | Host read byte |
| s_valid | input | 1 | Sequencer request present |
| s_ready | output | 1 | Sequencer request can be taken |
| s_we | input | 1 | Sequencer request is a write |
| s_seg | input | 8 | Sequencer segment number |
| s_off | input | 8 | Byte offset from the segment base |
| s_wdata | input | 8 | Sequencer write byte |
| s_rvalid | output | 1 | Sequencer read byte valid |
| s_rdata | output | 8 | Sequencer read byte |
| ram_viol | output | 1 | One-cycle pulse for an access that overran the array |

## Verification
The bench builds the block with its default parameters: 8-byte segments, 192 segments and a 400h fold distance. With these values the 11-bit host address reaches past the array end, up to 7FFh. The largest sequencer pointer and offset, 255*8+255, also overruns the array. The swap window covers the first eight host bytes. Both fold paths, the byte swap and a same-byte write clash can therefore be driven directly, and the folded locations are read back through the opposite port.

// File: rtl/seg_ram_pkg.sv
package seg_ram_pkg;
  // Host byte order seen on the bus
  typedef enum logic {ORDER_LITTLE = 1'b0, ORDER_BIG = 1'b1} byte_order_e;

  // Width needed to hold a scaled segment base plus an offset
  function automatic int raw_width(input int ptr_w, input int seg_sh, input int off_w);
    int hi;
    hi = (ptr_w + seg_sh > off_w) ? ptr_w + seg_sh : off_w;
    return hi + 1;
  endfunction
endpackage

// File: rtl/seg_scale.sv
module seg_scale #(
  parameter int PTR_W  = 8,
  parameter int OFF_W  = 8,
  parameter int SEG_SH = 3,
  parameter int RAW_W  = 12
) (
  input  logic [PTR_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [RAW_W-1:0] raw
);
  // segment base = pointer shifted by log2(segment size)
  always_comb raw = (RAW_W'(seg) << SEG_SH) + RAW_W'(off);
endmodule

// File: rtl/host_swap.sv
module host_swap #(
  parameter int AW        = 11,
  parameter int SWAP_SPAN = 8
) (
  input  logic          big_end,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);
  logic in_window;
  always_comb begin
    in_window = addr_in < AW'(SWAP_SPAN);
    addr_out  = addr_in;
    if (big_end && in_window) addr_out[0] = ~addr_in[0];
  end
endmodule

// File: rtl/seg_fold.sv
module seg_fold #(
  parameter int IN_W     = 12,
  parameter int OUT_W    = 11,
  parameter int DEPTH    = 1536,
  parameter int FOLD_SUB = 1024
) (
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] phys,
  output logic             over
);
  always_comb begin
    over = raw >= IN_W'(DEPTH);
    phys = over ? OUT_W'(raw - IN_W'(FOLD_SUB)) : OUT_W'(raw);
  end
endmodule

// File: rtl/dp_bytes.sv
module dp_bytes #(
  parameter int DEPTH = 1536,
  parameter int AW    = 11,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_rd,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_rd
);
  logic [DW-1:0] mem [DEPTH];

  // Reads return the content held before this edge's writes
  always_ff @(posedge clk) begin
    if (a_en && !a_we) a_rd <= mem[a_addr];
    if (b_en && !b_we) b_rd <= mem[b_addr];
    if (a_en && a_we) mem[a_addr] <= a_wd;
    if (b_en && b_we) mem[b_addr] <= b_wd;
  end
endmodule

// File: rtl/seg_dpram.sv
module seg_dpram #(
  parameter int SEG_BYTES = 8,
  parameter int NUM_SEGS  = 192,
  parameter int HADDR_W   = 11,
  parameter int PTR_W     = 8,
  parameter int OFF_W     = 8,
  parameter int DATA_W    = 8,
  parameter int FOLD_SUB  = 1024,
  parameter int SWAP_SPAN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_big_end,
  input  logic               h_valid,
  output logic               h_ready,
  input  logic               h_we,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0]  h_wdata,
  output logic               h_rvalid,
  output logic [DATA_W-1:0]  h_rdata,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic               s_we,
  input  logic [PTR_W-1:0]   s_seg,
  input  logic [OFF_W-1:0]   s_off,
  input  logic [DATA_W-1:0]  s_wdata,
  output logic               s_rvalid,
  output logic [DATA_W-1:0]  s_rdata,
  output logic               ram_viol
);
  import seg_ram_pkg::*;

  localparam int DEPTH  = SEG_BYTES * NUM_SEGS;
  localparam int MEM_AW = $clog2(DEPTH);
  localparam int SEG_SH = $clog2(SEG_BYTES);
  localparam int RAW_W  = raw_width(PTR_W, SEG_SH, OFF_W);

  byte_order_e order;
  assign order = byte_order_e'(h_big_end);

  // ---------------- host address path ----------------
  logic [HADDR_W-1:0] h_swapped;
  logic [MEM_AW-1:0]  h_phys;
  logic               h_over;

  host_swap #(.AW(HADDR_W), .SWAP_SPAN(SWAP_SPAN)) u_swap (
    .big_end (order == ORDER_BIG),
    .addr_in (h_addr),
    .addr_out(h_swapped)
  );

  seg_fold #(.IN_W(HADDR_W), .OUT_W(MEM_AW), .DEPTH(DEPTH), .FOLD_SUB(FOLD_SUB)) u_hfold (
    .raw (h_swapped),
    .phys(h_phys),
    .over(h_over)
  );

  // ---------------- sequencer address path ----------------
  logic [RAW_W-1:0]  s_raw;
  logic [MEM_AW-1:0] s_phys;
  logic              s_over;

  seg_scale #(.PTR_W(PTR_W), .OFF_W(OFF_W), .SEG_SH(SEG_SH), .RAW_W(RAW_W)) u_scale (
    .seg(s_seg),
    .off(s_off),
    .raw(s_raw)
  );

  seg_fold #(.IN_W(RAW_W), .OUT_W(MEM_AW), .DEPTH(DEPTH), .FOLD_SUB(FOLD_SUB)) u_sfold (
    .raw (s_raw),
    .phys(s_phys),
    .over(s_over)
  );

  // ---------------- arbitration ----------------
  logic clash, h_take, s_take;
  always_comb begin
    clash   = h_valid && h_we && s_valid && s_we && (h_phys == s_phys);
    h_ready = 1'b1;
    s_ready = !clash;
    h_take  = h_valid;
    s_take  = s_valid && s_ready;
  end

  dp_bytes #(.DEPTH(DEPTH), .AW(MEM_AW), .DW(DATA_W)) u_mem (
    .clk   (clk),
    .a_en  (h_take),
    .a_we  (h_we),
    .a_addr(h_phys),
    .a_wd  (h_wdata),
    .a_rd  (h_rdata),
    .b_en  (s_take),
    .b_we  (s_we),
    .b_addr(s_phys),
    .b_wd  (s_wdata),
    .b_rd  (s_rdata)
  );

  // ---------------- strobes ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rvalid <= 1'b0;
      s_rvalid <= 1'b0;
      ram_viol <= 1'b0;
    end else begin
      h_rvalid <= h_take && !h_we;
      s_rvalid <= s_take && !s_we;
      ram_viol <= (h_take && h_over) || (s_take && s_over);
    end
  end

  // ---------------- assertions ----------------
  AST_SWAP_LOW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_big_end && h_addr < HADDR_W'(SWAP_SPAN)) |-> (h_phys[0] != h_addr[0])); // R3

  AST_HOST_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid |-> (h_phys < MEM_AW'(DEPTH))); // R4

  AST_SEQ_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> (s_phys < MEM_AW'(DEPTH))); // R5

  AST_SEQ_OVERRUN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_raw >= RAW_W'(DEPTH)) |=> ram_viol); // R6

  AST_VIOL_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ram_viol |-> $past(h_valid || s_valid)); // R6

  AST_NO_SAME_BYTE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (h_take && h_we && s_take && s_we) |-> (h_phys != s_phys)); // R7

  AST_STALL_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> (s_valid && $stable(s_seg) && $stable(s_off))); // R7
endmodule

// File: tb/sim_seg_dpram.sv
module sim_seg_dpram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic       h_big_end = 0, h_valid = 0, h_we = 0;
  logic [10:0] h_addr = '0;
  logic [7:0] h_wdata = '0;
  logic       s_valid = 0, s_we = 0;
  logic [7:0] s_seg = '0, s_off = '0, s_wdata = '0;
  logic       h_ready, h_rvalid, s_ready, s_rvalid, ram_viol;
  logic [7:0] h_rdata, s_rdata;

  seg_dpram u0 (
    .clk(clk), .rst_n(rst_n), .h_big_end(h_big_end),
    .h_valid(h_valid), .h_ready(h_ready), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_we(s_we), .s_seg(s_seg),
    .s_off(s_off), .s_wdata(s_wdata), .s_rvalid(s_rvalid), .s_rdata(s_rdata),
    .ram_viol(ram_viol)
  );

  int n_run = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // we, be, addr, wdata, expected read byte, expected violation
  localparam int NV = 14;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 1'b0, 11'h040, 8'hA1, 8'h00, 1'b0},
    {1'b0, 1'b0, 11'h040, 8'h00, 8'hA1, 1'b0},
    {1'b1, 1'b0, 11'h5FF, 8'hB2, 8'h00, 1'b0},
    {1'b0, 1'b0, 11'h5FF, 8'h00, 8'hB2, 1'b0},
    {1'b1, 1'b0, 11'h600, 8'hC3, 8'h00, 1'b1},
    {1'b0, 1'b0, 11'h200, 8'h00, 8'hC3, 1'b0},
    {1'b1, 1'b0, 11'h3FF, 8'hD4, 8'h00, 1'b0},
    {1'b0, 1'b0, 11'h7FF, 8'h00, 8'hD4, 1'b1},
    {1'b1, 1'b1, 11'h002, 8'hE5, 8'h00, 1'b0},
    {1'b0, 1'b0, 11'h003, 8'h00, 8'hE5, 1'b0},
    {1'b1, 1'b0, 11'h002, 8'hF6, 8'h00, 1'b0},
    {1'b0, 1'b1, 11'h003, 8'h00, 8'hF6, 1'b0},
    {1'b1, 1'b1, 11'h010, 8'h77, 8'h00, 1'b0},
    {1'b0, 1'b0, 11'h010, 8'h00, 8'h77, 1'b0}
  };

  task automatic host_op(input logic we, input logic be, input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    h_valid = 1; h_we = we; h_big_end = be; h_addr = a; h_wdata = d;
    @(posedge clk); #2;
    h_valid = 0; h_we = 0; h_big_end = 0;
  endtask

  task automatic seq_op(input logic we, input logic [7:0] sg, input logic [7:0] of, input logic [7:0] d);
    @(negedge clk);
    s_valid = 1; s_we = we; s_seg = sg; s_off = of; s_wdata = d;
    @(posedge clk); #2;
    s_valid = 0; s_we = 0;
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_run++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    chk("R9 h_rvalid", 16'(h_rvalid), 16'h0);
    chk("R9 s_rvalid", 16'(s_rvalid), 16'h0);
    chk("R9 ram_viol", 16'(ram_viol), 16'h0);
    chk("R9 h_ready", 16'(h_ready), 16'h1);
    @(negedge clk); rst_n = 1;

    // Table walk: R1 storage, R3 swap, R4 host fold, R6 pulse
    for (int i = 0; i < NV; i++) begin
      host_op(VEC[i][29], VEC[i][28], VEC[i][27:17], VEC[i][16:9]);
      chk($sformatf("R6 viol vec%0d", i), 16'(ram_viol), 16'(VEC[i][0]));
      chk($sformatf("R1 rvalid vec%0d", i), 16'(h_rvalid), 16'(!VEC[i][29]));
      if (!VEC[i][29]) chk($sformatf("R1 R3 R4 rdata vec%0d", i), 16'(h_rdata), 16'(VEC[i][8:1]));
    end

    // R2 sequencer write, host read
    seq_op(1, 8'd8, 8'd3, 8'h11);
    chk("R6 seq in range no viol", 16'(ram_viol), 16'h0);
    host_op(0, 0, 11'h043, 8'h00);
    chk("R2 seg*8+off", 16'(h_rdata), 16'h11);
    seq_op(0, 8'd8, 8'd0, 8'h00);
    chk("R2 s_rvalid", 16'(s_rvalid), 16'h1);
    chk("R2 s_rdata", 16'(s_rdata), 16'hA1);

    // R5 sequencer fold, R6 single pulse
    seq_op(1, 8'd200, 8'd5, 8'h33);
    chk("R6 seq overrun viol", 16'(ram_viol), 16'h1);
    @(posedge clk); #2;
    chk("R6 pulse one cycle", 16'(ram_viol), 16'h0);
    host_op(0, 0, 11'h245, 8'h00);
    chk("R5 folded seq write", 16'(h_rdata), 16'h33);
    host_op(1, 0, 11'h4F7, 8'h44);
    seq_op(0, 8'd255, 8'd255, 8'h00);
    chk("R5 max pointer fold", 16'(s_rdata), 16'h44);
    chk("R6 seq read overrun viol", 16'(ram_viol), 16'h1);

    // R7 same-byte clash
    @(negedge clk);
    h_valid = 1; h_we = 1; h_addr = 11'h100; h_wdata = 8'h5A;
    s_valid = 1; s_we = 1; s_seg = 8'd32; s_off = 8'd0; s_wdata = 8'hA5;
    #1;
    chk("R7 s_ready low on clash", 16'(s_ready), 16'h0);
    chk("R7 h_ready high", 16'(h_ready), 16'h1);
    @(negedge clk);
    h_valid = 0; h_we = 0;
    #1;
    chk("R7 s_ready back", 16'(s_ready), 16'h1);
    @(posedge clk); #2;
    s_valid = 0; s_we = 0;
    host_op(0, 0, 11'h100, 8'h00);
    chk("R7 seq write lands last", 16'(h_rdata), 16'hA5);

    // R7 different bytes together
    @(negedge clk);
    h_valid = 1; h_we = 1; h_addr = 11'h101; h_wdata = 8'h66;
    s_valid = 1; s_we = 1; s_seg = 8'd32; s_off = 8'd2; s_wdata = 8'h88;
    #1;
    chk("R7 no stall distinct", 16'(s_ready), 16'h1);
    @(posedge clk); #2;
    h_valid = 0; h_we = 0; s_valid = 0; s_we = 0;
    host_op(0, 0, 11'h101, 8'h00);
    chk("R7 host byte", 16'(h_rdata), 16'h66);
    host_op(0, 0, 11'h102, 8'h00);
    chk("R7 seq byte", 16'(h_rdata), 16'h88);

    // R8 read during write to same byte
    @(negedge clk);
    h_valid = 1; h_we = 0; h_addr = 11'h043;
    s_valid = 1; s_we = 1; s_seg = 8'd8; s_off = 8'd3; s_wdata = 8'h22;
    @(posedge clk); #2;
    h_valid = 0; s_valid = 0; s_we = 0;
    chk("R8 old byte returned", 16'(h_rdata), 16'h11);
    host_op(0, 0, 11'h043, 8'h00);
    chk("R8 new byte stored", 16'(h_rdata), 16'h22);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule